// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This unit accepts a 64-bit register image and a format code. It turns the value into one internal operand form that downstream arithmetic can use without knowing where the value came from. The four source formats are signed 32-bit integer, signed 64-bit integer, IEEE single and IEEE double. The output carries:

- a sign;
- a signed unbiased exponent;
- a 66-bit mantissa whose leading one sits at bit 64;
- a class code;
- an invalid-operand flag, raised when the input is a signalling NaN.

The value of a number-class result is `mant * 2^(exp - 64)`.

Denormals and integers are normalized by a left-shift loop. The loop moves the mantissa one position per cycle and lowers the exponent by one for each step. Handshakes sit at both ends. An operand is taken when `in_valid` meets `in_ready`. The result is shown with `out_valid` and held until `out_ready` takes it. Only one operand is in flight at a time.

Class codes: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN.

Top module: `fp_unpack`

## Requirements
- R1: The output sign is the top bit of the selected word: bit 31 of the register for format 0, and bit 63 for formats 1, 2 and 3. For an unknown format code the sign is 0.
- R2: For integer formats, a zero input gives class 0 with exponent 0 and mantissa 0. Any other value has its two's-complement magnitude placed in mantissa bits 63..0 with exponent 64, and is then normalized. The result satisfies `mant * 2^(exp-64) = |value|`, with class 1.
- R3: An IEEE input with exponent field 0 and fraction 0 gives class 0, with exponent 0 and mantissa 0.
- R4: An IEEE input with exponent field 0 and a nonzero fraction is a denormal. It gets exponent `1 - bias`, takes no hidden one, and has its fraction left-aligned at mantissa bit 63. It is then normalized as a class 1 result.
- R5: A normal IEEE input gets exponent `field - bias` and mantissa `{2'b01, fraction left-aligned at bit 63, zeros below}`, with class 1 and no shifting.
- R6: An IEEE input with an all-ones exponent field and a zero fraction gives class 2, with exponent 0 and mantissa 0.
- R7: An all-ones exponent with a nonzero fraction whose top bit (the quiet bit) is set gives class 3. The fraction is left-aligned at bit 63, the exponent is 0, and the invalid flag is clear.
- R8: An all-ones exponent with a nonzero fraction and a clear quiet bit gives class 4, with the invalid flag set. The mantissa holds the fraction with bit 63 forced to one.
- R9: Format codes and field layouts are as follows:
  - code 0: 32-bit integer taken from register bits 31..0;
  - code 1: 64-bit integer;
  - code 2: single, taken from register bits 63..32, with an 8-bit exponent, bias 127 and a 23-bit fraction;
  - code 3: double, with an 11-bit exponent, bias 1023 and a 52-bit fraction.
  
  Codes 4 to 7 raise `out_fmt_err` and give class 0 with zero exponent and mantissa.
- R10: `in_ready` is high only while the unit is idle. The result appears `1 + s` cycles after acceptance, where `s` is the number of normalization shifts. While `out_valid` is high and `out_ready` is low, all outputs hold.
- R11: Every class 1 result has mantissa bit 64 set and bit 65 clear. `out_sticky` is always 0.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle, operand taken on this edge |
| in_word | input | 64 | Register image |
| in_fmt | input | 3 | Format code (R9) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result |
| out_sign | output | 1 | Sign |
| out_exp | output | 13 | Signed unbiased exponent |
| out_mant | output | 66 | Mantissa, leading one at bit 64 |
| out_class | output | 3 | Class code |
| out_invalid | output | 1 | Signalling-NaN input seen |
| out_fmt_err | output | 1 | Unknown format code |
| out_sticky | output | 1 | Sticky bit, always zero |

## Verification
The assertions assume that the consumer may stall for any length of time, and that `in_valid` only matters while `in_ready` is high. The bench follows both assumptions. It offers each operand only when the unit is idle and drops `in_valid` after the accepting edge. It holds `out_ready` low for a few cycles before taking each result, so the stability checks are exercised. The inputs cover every class in every format, including extreme shift counts: integer 1, which needs 64 shifts, and the smallest double denormal, which needs 52. Together these stay inside the checker's bounded-latency window.

// File: rtl/fp_unpack.sv
module fp_unpack #(
  parameter int EXP_W = 13,
  parameter int FMT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [63:0]             in_word,
  input  logic [FMT_W-1:0]        in_fmt,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_sign,
  output logic signed [EXP_W-1:0] out_exp,
  output logic [65:0]             out_mant,
  output logic [2:0]              out_class,
  output logic                    out_invalid,
  output logic                    out_fmt_err,
  output logic                    out_sticky
);
  localparam int LEAD = 64;
  localparam logic [2:0] C_ZERO = 3'd0, C_NUM = 3'd1, C_INF = 3'd2,
                         C_QNAN = 3'd3, C_SNAN = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_NORM, S_DONE} st_t;
  st_t st;

  logic                    n_sign, n_inv, n_err;
  logic signed [EXP_W-1:0] n_exp, bias, ef, emax;
  logic [65:0]             n_mant;
  logic [2:0]              n_cls;
  logic [63:0]             mag, fr;
  logic                    is_int, is_ieee;

  always_comb begin
    n_sign = 1'b0; n_inv = 1'b0; n_err = 1'b0;
    n_exp = '0; n_mant = '0; n_cls = C_ZERO;
    mag = '0; fr = '0; bias = '0; ef = '0; emax = '0;
    is_int = 1'b0; is_ieee = 1'b0;
    case (in_fmt)
      FMT_W'(0): begin
        is_int = 1'b1; n_sign = in_word[31];
        mag = {32'd0, in_word[31] ? (~in_word[31:0] + 32'd1) : in_word[31:0]};
      end
      FMT_W'(1): begin
        is_int = 1'b1; n_sign = in_word[63];
        mag = in_word[63] ? (~in_word + 64'd1) : in_word;
      end
      FMT_W'(2): begin
        is_ieee = 1'b1; n_sign = in_word[63];
        ef = EXP_W'(in_word[62:55]); fr = {in_word[54:32], 41'd0};
        bias = EXP_W'(127); emax = EXP_W'(255);
      end
      FMT_W'(3): begin
        is_ieee = 1'b1; n_sign = in_word[63];
        ef = EXP_W'(in_word[62:52]); fr = {in_word[51:0], 12'd0};
        bias = EXP_W'(1023); emax = EXP_W'(2047);
      end
      default: n_err = 1'b1;
    endcase
    if (is_int && mag != '0) begin
      n_cls = C_NUM; n_exp = EXP_W'(LEAD); n_mant = {2'b00, mag};
    end
    if (is_ieee) begin
      if (ef == '0) begin
        if (fr != '0) begin
          n_cls = C_NUM; n_exp = EXP_W'(1) - bias; n_mant = {2'b00, fr};
        end
      end else if (ef == emax) begin
        if (fr == '0) n_cls = C_INF;
        else begin
          n_mant = {2'b00, 1'b1, fr[62:0]};
          n_cls  = fr[63] ? C_QNAN : C_SNAN;
          n_inv  = ~fr[63];
        end
      end else begin
        n_cls = C_NUM; n_exp = ef - bias; n_mant = {2'b01, fr};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      out_sign <= 1'b0; out_exp <= '0; out_mant <= '0;
      out_class <= C_ZERO; out_invalid <= 1'b0; out_fmt_err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          out_sign <= n_sign; out_exp <= n_exp; out_mant <= n_mant;
          out_class <= n_cls; out_invalid <= n_inv; out_fmt_err <= n_err;
          st <= (n_cls == C_NUM && !n_mant[LEAD]) ? S_NORM : S_DONE;
        end
        S_NORM: begin
          out_mant <= out_mant << 1;
          out_exp  <= out_exp - EXP_W'(1);
          if (out_mant[LEAD-1]) st <= S_DONE;
        end
        S_DONE: if (out_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign in_ready   = (st == S_IDLE);
  assign out_valid  = (st == S_DONE);
  assign out_sticky = 1'b0;
endmodule

module fp_unpack_chk #(
  parameter int EXP_W = 13
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic                    out_sign,
  input logic signed [EXP_W-1:0] out_exp,
  input logic [65:0]             out_mant,
  input logic [2:0]              out_class,
  input logic                    out_invalid,
  input logic                    out_fmt_err,
  input logic                    out_sticky
);
  logic [7:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) busy_cnt <= '0;
    else if (in_ready || out_valid) busy_cnt <= '0;
    else busy_cnt <= busy_cnt + 8'd1;
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mant) && $stable(out_exp)
      && $stable(out_class) && $stable(out_sign) && $stable(out_invalid));
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  p_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= 8'd64);
  p_lead_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 3'd1 |-> out_mant[64] && !out_mant[65]);
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_sticky == 1'b0);
  p_snan_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_invalid == (out_class == 3'd4)));
  p_nan_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_class == 3'd3 || out_class == 3'd4) |-> out_mant[63]);
  p_fmt_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fmt_err |-> out_class == 3'd0 && out_mant == '0 && !out_sign);
  p_class_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_class <= 3'd4);
endmodule

bind fp_unpack fp_unpack_chk #(.EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_sign(out_sign), .out_exp(out_exp),
  .out_mant(out_mant), .out_class(out_class), .out_invalid(out_invalid),
  .out_fmt_err(out_fmt_err), .out_sticky(out_sticky));

// File: tb/fp_unpack_bench.sv
`timescale 1ns/1ps
module fp_unpack_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [63:0] in_word = '0;
  logic [2:0] in_fmt = '0;
  logic in_ready, out_valid, out_sign, out_invalid, out_fmt_err, out_sticky;
  logic signed [12:0] out_exp;
  logic [65:0] out_mant;
  logic [2:0] out_class;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  fp_unpack u_fp_unpack (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_fmt(in_fmt), .out_valid(out_valid), .out_ready(out_ready),
    .out_sign(out_sign), .out_exp(out_exp), .out_mant(out_mant), .out_class(out_class),
    .out_invalid(out_invalid), .out_fmt_err(out_fmt_err), .out_sticky(out_sticky));

  // expected values
  logic e_sign, e_inv, e_err;
  int e_exp, e_shifts;
  logic [65:0] e_mant;
  logic [2:0] e_cls;

  task automatic chk(input string req, input string what, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic ieee(input int ef, input int emax, input int bias, input logic [63:0] fr);
    if (ef == 0) begin
      if (fr != 0) begin e_cls = 3'd1; e_exp = 1 - bias; e_mant = {2'b00, fr}; end
    end else if (ef == emax) begin
      if (fr == 0) e_cls = 3'd2;
      else begin
        e_mant = {2'b00, fr}; e_mant[63] = 1'b1;
        e_cls = fr[63] ? 3'd3 : 3'd4; e_inv = !fr[63];
      end
    end else begin
      e_cls = 3'd1; e_exp = ef - bias; e_mant = {2'b01, fr};
    end
  endtask

  task automatic model(input logic [63:0] w, input logic [2:0] f);
    logic [63:0] m;
    e_sign = 0; e_inv = 0; e_err = 0; e_exp = 0; e_mant = '0; e_cls = 3'd0; e_shifts = 0;
    case (f)
      3'd0: begin
        e_sign = w[31];
        m = {32'd0, w[31] ? 32'(-w[31:0]) : w[31:0]};
        if (m != 0) begin e_cls = 3'd1; e_exp = 64; e_mant = {2'b00, m}; end
      end
      3'd1: begin
        e_sign = w[63];
        m = w[63] ? -w : w;
        if (m != 0) begin e_cls = 3'd1; e_exp = 64; e_mant = {2'b00, m}; end
      end
      3'd2: begin e_sign = w[63]; ieee(int'(w[62:55]), 255, 127, {w[54:32], 41'd0}); end
      3'd3: begin e_sign = w[63]; ieee(int'(w[62:52]), 2047, 1023, {w[51:0], 12'd0}); end
      default: e_err = 1;
    endcase
    if (e_cls == 3'd1)
      while (!e_mant[64]) begin e_mant = e_mant << 1; e_exp--; e_shifts++; end
  endtask

  task automatic run(input string req, input logic [63:0] w, input logic [2:0] f);
    int lat;
    model(w, f);
    @(negedge clk);
    in_word = w; in_fmt = f; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_word = ~w;
    lat = 1;
    while (!out_valid) begin
      if (in_ready) begin checks++; failures++; $display("FAIL R10 in_ready high while busy actual=1 expected=0"); end
      lat++;
      @(negedge clk);
    end
    chk("R10", "latency", 66'(lat), 66'(1 + e_shifts));
    chk("R1", "sign", 66'(out_sign), 66'(e_sign));
    chk(req, "exp", 66'(int'(out_exp)), 66'(e_exp));
    chk(req, "mant", out_mant, e_mant);
    chk(req, "class", 66'(out_class), 66'(e_cls));
    chk("R8", "invalid", 66'(out_invalid), 66'(e_inv));
    chk("R9", "fmt_err", 66'(out_fmt_err), 66'(e_err));
    chk("R11", "sticky", 66'(out_sticky), 66'd0);
    repeat (2) @(negedge clk);
    chk("R10", "held valid", 66'(out_valid), 66'd1);
    chk("R10", "held mant", out_mant, e_mant);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R10", "valid drop", 66'(out_valid), 66'd0);
    chk("R10", "ready back", 66'(in_ready), 66'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "reset valid", 66'(out_valid), 66'd0);
    chk("R12", "reset ready", 66'(in_ready), 66'd1);
    rst_n = 1'b1;
    // R2 integers (code 0 ignores high half, R9)
    run("R2", 64'hFFFF_FFFF_0000_0000, 3'd0);
    run("R2", 64'hABCD_0000_0000_0001, 3'd0);
    run("R2", 64'h0000_0000_FFFF_FFFF, 3'd0);
    run("R2", 64'h1234_5678_8000_0000, 3'd0);
    run("R2", 64'h0000_0000_0000_3039, 3'd0);
    run("R2", 64'h0, 3'd1);
    run("R2", 64'hFFFF_FFFF_FFFF_FFFB, 3'd1);
    run("R2", 64'h8000_0000_0000_0000, 3'd1);
    run("R2", 64'h0000_0100_0000_0000, 3'd1);
    run("R2", 64'h0000_0000_0000_0001, 3'd1);
    // single (R9 reads high half)
    run("R5", 64'h3F80_0000_DEAD_BEEF, 3'd2);
    run("R3", 64'h8000_0000_1234_5678, 3'd2);
    run("R4", 64'h0000_0001_FFFF_FFFF, 3'd2);
    run("R4", 64'h8040_0000_0000_0000, 3'd2);
    run("R6", 64'hFF80_0000_0000_0000, 3'd2);
    run("R7", 64'h7FC0_0001_0000_0000, 3'd2);
    run("R8", 64'h7F80_0001_0000_0000, 3'd2);
    // double
    run("R5", 64'h3FF8_0000_0000_0000, 3'd3);
    run("R5", 64'h7FEF_FFFF_FFFF_FFFF, 3'd3);
    run("R3", 64'h0000_0000_0000_0000, 3'd3);
    run("R4", 64'h0000_0000_0000_0001, 3'd3);
    run("R4", 64'h800F_FFFF_FFFF_FFFF, 3'd3);
    run("R6", 64'hFFF0_0000_0000_0000, 3'd3);
    run("R7", 64'h7FF8_0000_0000_0000, 3'd3);
    run("R8", 64'hFFF0_0000_0000_0001, 3'd3);
    run("R8", 64'h7FF4_0000_0000_0000, 3'd3);
    // unknown codes
    run("R9", 64'hFFFF_FFFF_FFFF_FFFF, 3'd5);
    run("R9", 64'h3FF0_0000_0000_0000, 3'd7);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule